// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block sits beside a UART and steers a half-duplex line transceiver. It drives a transmit enable and a receive enable whose asserted levels and behaviour are set by an 8-bit control register. It also decides which shared package pins carry those enables and which carry the UART's ordinary modem-control and ready outputs. Software writes the register through a small write port and can read it back.

The UART supplies a raw "transmitter busy" level. The block samples this level only on baud-clock boundaries and holds it in a registered activity flag, so an enable can only change at a bit boundary. The flag goes high when the leading edge of the first start bit appears. It goes low once the last stop bit has shifted out and both the holding and shift registers are empty. Each enable is formed from this flag and from its polarity and mode bits. A 2-bit routing field then places the enables on the chosen pins. Every pin the routing does not claim passes its normal signal through unchanged.

Top module: `rs485_dir_ctl`

## Requirements
- R1: A synchronous active-low reset clears the control register to 0x00 and the activity flag to 0. From the next edge onward, every pin carries its normal input: rts_pin=rts_in, dtr_pin=dtr_in, txrdy_pin=txrdy_in, rxrdy_pin=rxrdy_in.
- R2: A cycle with cfg_we=1 loads cfg_wdata into the register at that clock edge. cfg_rdata shows the new value from the next cycle, with bits 3:2 always reading 0.
- R3: The activity flag takes the value of tx_busy at a clock edge where baud_tick=1. It keeps its value at every other edge.
- R4: With bit 6 = 0 the receive enable equals bit 7 (the receive polarity), whatever the flag is.
- R5: With bit 6 = 1 the receive enable is the inverse of bit 7 while the flag is 1, and equals bit 7 while the flag is 0.
- R6: With bits 1:0 = 00 all four pins carry their normal inputs.
- R7: With bits 1:0 = 01, rts_pin carries the transmit enable. The other three pins carry their normal inputs.
- R8: With bits 1:0 = 10, dtr_pin carries the transmit enable. The other three pins carry their normal inputs.
- R9: With bits 1:0 = 11, txrdy_pin carries the transmit enable and rxrdy_pin carries the receive enable. rts_pin and dtr_pin carry their normal inputs.
- R10: With bits 1:0 = 11 and bit 4 = 0, the transmit enable equals bit 5 (the transmit polarity).
- R11: With bits 1:0 = 11 and bit 4 = 1, the transmit enable is the inverse of bit 5 while the flag is 1 and the inverse of bit 7 while the flag is 0.
- R12: With bits 1:0 = 01 or 10, bit 4 and the flag have no effect. The transmit enable equals bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read-back value |
| baud_tick | input | 1 | One-cycle strobe on each baud-clock boundary |
| tx_busy | input | 1 | Raw transmitter-active level from the UART |
| rts_in | input | 1 | Normal RTS output of the UART |
| dtr_in | input | 1 | Normal DTR output of the UART |
| txrdy_in | input | 1 | Normal transmit-ready output of the UART |
| rxrdy_in | input | 1 | Normal receive-ready output of the UART |
| rts_pin | output | 1 | Shared pin: RTS or transmit enable |
| dtr_pin | output | 1 | Shared pin: DTR or transmit enable |
| txrdy_pin | output | 1 | Shared pin: transmit-ready or transmit enable |
| rxrdy_pin | output | 1 | Shared pin: receive-ready or receive enable |

## Verification
The assertions assume that baud_tick and tx_busy are driven by clean synchronous logic in the same clock domain. They also assume that tx_busy is sampled only through the tick, so any flag movement outside a tick counts as an error. The stimulus changes every input only away from the active edge. It varies the tick rate, the busy level and the register value independently, and it occasionally pulses reset mid-run, so every routing and mode combination is reached both with the flag high and with it low.

// File: rtl/rs485_dir_pkg.sv
// Package: shared types for the line direction controller.
// Assumes an 8-bit control register whose field positions are fixed by
// software: [7] rx polarity, [6] rx auto mode, [5] tx polarity,
// [4] tx auto mode, [3:2] reserved, [1:0] pin routing.
package rs485_dir_pkg;

    localparam int CFG_W = 8;

    // Which shared pins carry the enables.
    typedef enum logic [1:0] {
        ROUTE_OFF = 2'b00,
        ROUTE_RTS = 2'b01,
        ROUTE_DTR = 2'b10,
        ROUTE_RDY = 2'b11
    } route_e;

    typedef struct packed {
        logic       rx_pol;
        logic       rx_auto;
        logic       tx_pol;
        logic       tx_auto;
        logic [1:0] rsvd;
        route_e     route;
    } dir_cfg_t;

    // Clears the reserved field of a value written by software.
    function automatic dir_cfg_t clean_cfg(input logic [CFG_W-1:0] raw);
        dir_cfg_t c;
        c      = dir_cfg_t'(raw);
        c.rsvd = 2'b00;
        return c;
    endfunction

endpackage

// File: rtl/rs485_cfg_reg.sv
// Module: control register with write port and read-back.
// Assumes the writer needs no byte enables. The reserved field is forced
// to zero on write, so it always reads back as zero.
module rs485_cfg_reg
    import rs485_dir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output dir_cfg_t         cfg_q
);

    // Register update: reset clears, write loads a cleaned value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= clean_cfg(wdata);
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.rsvd == 2'b00); // R2

    AST_RST_CLEAR: assert property (@(posedge clk)
        !rst_n |=> cfg_q == '0); // R1

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cfg_q.route == route_e'($past(wdata[1:0]))); // R2

endmodule

// File: rtl/rs485_tx_track.sv
// Module: registered transmitter-activity flag.
// Assumes tx_busy is a synchronous level that is high from the first start
// bit until the last stop bit has left and both holding and shift stages
// are empty. With BAUD_ALIGN=1 the flag moves only on baud_tick, so the
// enables derived from it cannot change in the middle of a bit.
module rs485_tx_track #(
    parameter bit BAUD_ALIGN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic tx_busy,
    output logic tx_active
);

    generate
        if (BAUD_ALIGN) begin : g_aligned
            // Flag capture: sample busy only on a baud boundary.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tx_active <= 1'b0;
                end else if (baud_tick) begin
                    tx_active <= tx_busy;
                end
            end

            AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !baud_tick |=> $stable(tx_active)); // R3

            AST_FLAG_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
                baud_tick |=> tx_active == $past(tx_busy)); // R3
        end else begin : g_free
            // Flag capture: sample busy every cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tx_active <= 1'b0;
                end else begin
                    tx_active <= tx_busy;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rs485_enable_gen.sv
// Module: forms the receive and transmit enable levels.
// Assumes the polarity bits give the asserted level. The receive enable
// idles at its polarity and inverts while transmitting in auto mode. The
// full transmit enable (ready-pin routing) idles at the inverse of the
// receive polarity in auto mode. The simple transmit enable used by the
// modem-pin routings is always the transmit polarity.
module rs485_enable_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pol,
    input  logic rx_auto,
    input  logic tx_pol,
    input  logic tx_auto,
    input  logic tx_active,
    output logic rx_en,
    output logic tx_en_full,
    output logic tx_en_simple
);

    // Receive enable: polarity, optionally inverted during transmission.
    always_comb begin
        rx_en = rx_pol;
        if (rx_auto && tx_active) begin
            rx_en = ~rx_pol;
        end
    end

    // Full transmit enable: static level or activity-driven level.
    always_comb begin
        if (!tx_auto) begin
            tx_en_full = tx_pol;
        end else if (tx_active) begin
            tx_en_full = ~tx_pol;
        end else begin
            tx_en_full = ~rx_pol;
        end
    end

    // Simple transmit enable: mode bit has no effect here.
    always_comb begin
        tx_en_simple = tx_pol;
    end

    AST_RX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_auto && tx_active) |-> rx_en != rx_pol); // R5

    AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> rx_en == rx_pol); // R4

    AST_TX_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_auto && !tx_active) |-> tx_en_full != rx_pol); // R11

endmodule

// File: rtl/rs485_pin_mux.sv
// Module: places enables or normal signals on the four shared pins.
// Assumes the routing code is stable within a cycle; the output is
// combinational from the routing code and the pin sources.
module rs485_pin_mux
    import rs485_dir_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  route_e route,
    input  logic   rx_en,
    input  logic   tx_en_full,
    input  logic   tx_en_simple,
    input  logic   rts_in,
    input  logic   dtr_in,
    input  logic   txrdy_in,
    input  logic   rxrdy_in,
    output logic   rts_pin,
    output logic   dtr_pin,
    output logic   txrdy_pin,
    output logic   rxrdy_pin
);

    // Pin selection: default pass-through, routing overrides one or two pins.
    always_comb begin
        rts_pin   = rts_in;
        dtr_pin   = dtr_in;
        txrdy_pin = txrdy_in;
        rxrdy_pin = rxrdy_in;
        unique case (route)
            ROUTE_OFF: ;
            ROUTE_RTS: rts_pin = tx_en_simple;
            ROUTE_DTR: dtr_pin = tx_en_simple;
            ROUTE_RDY: begin
                txrdy_pin = tx_en_full;
                rxrdy_pin = rx_en;
            end
            default: ;
        endcase
    end

    AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        route == ROUTE_OFF |-> {rts_pin, dtr_pin, txrdy_pin, rxrdy_pin}
                               == {rts_in, dtr_in, txrdy_in, rxrdy_in}); // R6

    AST_RDY_KEEP_MODEM: assert property (@(posedge clk) disable iff (!rst_n)
        route == ROUTE_RDY |-> (rts_pin == rts_in && dtr_pin == dtr_in)); // R9

    AST_RTS_KEEP_REST: assert property (@(posedge clk) disable iff (!rst_n)
        route == ROUTE_RTS |-> (dtr_pin == dtr_in && txrdy_pin == txrdy_in
                                && rxrdy_pin == rxrdy_in)); // R7

    AST_DTR_KEEP_REST: assert property (@(posedge clk) disable iff (!rst_n)
        route == ROUTE_DTR |-> (rts_pin == rts_in && txrdy_pin == txrdy_in
                                && rxrdy_pin == rxrdy_in)); // R8

endmodule

// File: rtl/rs485_dir_ctl.sv
// Module: top of the half-duplex line direction controller.
// Assumes all inputs are synchronous to clk. The register is written
// through cfg_we/cfg_wdata, and transmitter activity is tracked on baud
// boundaries. The pins are combinational from registered state and the
// pass-through modem and ready inputs.
module rs485_dir_ctl
    import rs485_dir_pkg::*;
#(
    parameter bit BAUD_ALIGN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             baud_tick,
    input  logic             tx_busy,
    input  logic             rts_in,
    input  logic             dtr_in,
    input  logic             txrdy_in,
    input  logic             rxrdy_in,
    output logic             rts_pin,
    output logic             dtr_pin,
    output logic             txrdy_pin,
    output logic             rxrdy_pin
);

    dir_cfg_t cfg_q;
    logic     tx_active;
    logic     rx_en;
    logic     tx_en_full;
    logic     tx_en_simple;

    rs485_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    rs485_tx_track #(.BAUD_ALIGN(BAUD_ALIGN)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_busy   (tx_busy),
        .tx_active (tx_active)
    );

    rs485_enable_gen u_en (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_pol       (cfg_q.rx_pol),
        .rx_auto      (cfg_q.rx_auto),
        .tx_pol       (cfg_q.tx_pol),
        .tx_auto      (cfg_q.tx_auto),
        .tx_active    (tx_active),
        .rx_en        (rx_en),
        .tx_en_full   (tx_en_full),
        .tx_en_simple (tx_en_simple)
    );

    rs485_pin_mux u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .route        (cfg_q.route),
        .rx_en        (rx_en),
        .tx_en_full   (tx_en_full),
        .tx_en_simple (tx_en_simple),
        .rts_in       (rts_in),
        .dtr_in       (dtr_in),
        .txrdy_in     (txrdy_in),
        .rxrdy_in     (rxrdy_in),
        .rts_pin      (rts_pin),
        .dtr_pin      (dtr_pin),
        .txrdy_pin    (txrdy_pin),
        .rxrdy_pin    (rxrdy_pin)
    );

    // Read-back: register value as stored.
    always_comb begin
        cfg_rdata = cfg_q;
    end

    AST_SIMPLE_TX_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.route == ROUTE_RTS) |-> rts_pin == cfg_q.tx_pol); // R12

    AST_RDY_STATIC_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.route == ROUTE_RDY && !cfg_q.tx_auto)
            |-> txrdy_pin == cfg_q.tx_pol); // R10

endmodule

// File: tb/rs485_dir_ctl_tb.sv
module rs485_dir_ctl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       baud_tick = 1'b0;
    logic       tx_busy = 1'b0;
    logic       rts_in = 1'b0, dtr_in = 1'b0, txrdy_in = 1'b0, rxrdy_in = 1'b0;
    logic       rts_pin, dtr_pin, txrdy_pin, rxrdy_pin;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rs485_dir_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .baud_tick(baud_tick), .tx_busy(tx_busy),
        .rts_in(rts_in), .dtr_in(dtr_in), .txrdy_in(txrdy_in), .rxrdy_in(rxrdy_in),
        .rts_pin(rts_pin), .dtr_pin(dtr_pin), .txrdy_pin(txrdy_pin),
        .rxrdy_pin(rxrdy_pin)
    );

    // Bench model of the register and activity flag, from R1-style rules.
    logic [7:0] m_cfg  = '0;
    logic       m_flag = 1'b0;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_cfg  <= '0;
            m_flag <= 1'b0;
        end else begin
            if (cfg_we) m_cfg <= {cfg_wdata[7:4], 2'b00, cfg_wdata[1:0]};
            if (baud_tick) m_flag <= tx_busy;
        end
    end

    // Expected pins {rts, dtr, txrdy, rxrdy} from requirements R4..R12.
    function automatic logic [3:0] exp_pins(input logic [7:0] c, input logic f,
                                            input logic [3:0] ins);
        logic rx, txf, txs;
        logic [3:0] p;
        rx  = (c[6] && f) ? ~c[7] : c[7];
        txf = !c[4] ? c[5] : (f ? ~c[5] : ~c[7]);
        txs = c[5];
        p   = ins;
        case (c[1:0])
            2'b01: p[3] = txs;
            2'b10: p[2] = txs;
            2'b11: begin p[1] = txf; p[0] = rx; end
            default: ;
        endcase
        return p;
    endfunction

    function automatic string tag_of(input logic [7:0] c);
        case (c[1:0])
            2'b00: return "R6";
            2'b01: return "R7 R12";
            2'b10: return "R8 R12";
            default: return c[4] ? "R9 R11 R4 R5" : "R9 R10 R4 R5";
        endcase
    endfunction

    task automatic check(input string tag);
        logic [3:0] got, exp;
        got = {rts_pin, dtr_pin, txrdy_pin, rxrdy_pin};
        exp = exp_pins(m_cfg, m_flag, {rts_in, dtr_in, txrdy_in, rxrdy_in});
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s pins: actual=%b expected=%b", tag, got, exp);
        end
        total++;
        if (cfg_rdata !== m_cfg) begin
            bad++;
            $display("FAIL R2 rdata: actual=%h expected=%h", cfg_rdata, m_cfg);
        end
    endtask

    task automatic expect_bit(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
        end
    endtask

    // Advance one edge; leaves time at the following falling edge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        cyc();
        cfg_we = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1'b1;
        {rts_in, dtr_in, txrdy_in, rxrdy_in} = 4'b1010;
        cyc();
        check("R1");
        {rts_in, dtr_in, txrdy_in, rxrdy_in} = 4'b0101;
        #1;
        check("R1");

        // R2: reserved bits read back as zero.
        wr(8'hFF);
        expect_bit("R2 rsvd", |cfg_rdata[3:2], 1'b0);
        total++;
        if (cfg_rdata !== 8'hF3) begin
            bad++;
            $display("FAIL R2 readback: actual=%h expected=%h", cfg_rdata, 8'hF3);
        end

        // R3/R5: flag moves only on a tick; rx enable shows it on rxrdy_pin.
        wr(8'h43);
        tx_busy = 1'b1;
        cyc(); cyc();
        expect_bit("R3 hold", rxrdy_pin, 1'b0);
        baud_tick = 1'b1; cyc(); baud_tick = 1'b0; #1;
        expect_bit("R3 take R5", rxrdy_pin, 1'b1);
        tx_busy = 1'b0; cyc();
        expect_bit("R3 hold high", rxrdy_pin, 1'b1);

        // R12: mode bit and activity ignored on the modem-pin routing.
        wr(8'h11);
        expect_bit("R12 active", rts_pin, 1'b0);
        baud_tick = 1'b1; cyc(); baud_tick = 1'b0; #1;
        expect_bit("R12 idle", rts_pin, 1'b0);

        // R11: idle level in auto mode is the inverse of rx polarity.
        wr(8'h93);
        expect_bit("R11 idle", txrdy_pin, 1'b0);
        tx_busy = 1'b1; baud_tick = 1'b1; cyc(); baud_tick = 1'b0; #1;
        expect_bit("R11 active", txrdy_pin, 1'b1);

        // Random phase across all routings, modes and flag states.
        for (int i = 0; i < 4000; i++) begin
            cfg_we    = ($urandom_range(0, 7) == 0);
            cfg_wdata = 8'($urandom);
            baud_tick = ($urandom_range(0, 3) == 0);
            tx_busy   = ($urandom_range(0, 2) != 0);
            {rts_in, dtr_in, txrdy_in, rxrdy_in} = 4'($urandom);
            rst_n     = ($urandom_range(0, 299) != 0);
            cyc();
            check(rst_n ? tag_of(m_cfg) : "R1");
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule